// File: doc/BRIEF.md
# SDRAM Power-Up and Access Sequencer

This block sits on the controller side of a four-bank single-data-rate SDRAM and drives its command pins. After reset it holds the device quiet for a power-up wait, then brings it into service: it closes every bank, performs a series of auto-refresh cycles, and programs the mode register. The wait length is computed in clock cycles from a clock-frequency parameter and a wait time given in microseconds. Only after the mode register load does it open its user port.

Each accepted request carries a flat address and a read/write flag. The sequencer splits the address into bank, row and column fields. It opens the row with ACTIVE, issues one burst READ or WRITE, waits for the burst, and closes the bank with a single-bank PRECHARGE before it takes the next request. Every gap between commands is a parameter, and NOP fills each idle cycle. Data movement is handled elsewhere. Burst length and burst ordering come from the mode word that the block programs.

Top module: `sdram_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the command pins show NOP, CKE is high, every DQM bit is high, and both req_ready and init_done are low.
- R2: Command codes on {cs_n, ras_n, cas_n, we_n} are: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001 and LOAD MODE 0000. All pin outputs come from registers.
- R3: Counting rising edges after reset is released, the pins show only NOP up to edge INIT_CYC-1, where INIT_CYC = CLK_MHZ*INIT_US. PRECHARGE with sd_a[10]=1 (all banks) appears at edge INIT_CYC.
- R4: N_REF AUTO REFRESH commands follow. The first comes T_RP edges after the all-bank precharge and each later one comes T_RFC edges after the one before it.
- R5: LOAD MODE follows T_RFC edges after the last refresh, with sd_a equal to MODE_WORD and sd_ba equal to 0. init_done rises and DQM drops to all zeros on that same edge, and both stay that way.
- R6: req_ready stays low until init_done is high. It first rises T_MRD-1 edges after LOAD MODE. A request held valid during initialization produces no ACTIVE, READ or WRITE before that point.
- R7: The flat address is split as bank = req_addr[23:22], row = req_addr[21:9] and column = req_addr[8:0]. These fields are captured on acceptance, and later address changes have no effect on the access.
- R8: A request is accepted on a rising edge where req_valid and req_ready are both high. ACTIVE appears on that same edge, carrying the bank on sd_ba and the row on sd_a.
- R9: READ (req_we=0) or WRITE (req_we=1) appears exactly T_RCD edges after ACTIVE. It carries the same bank, the column on sd_a[8:0], and sd_a[10]=0.
- R10: A PRECHARGE of the open bank, with sd_a[10]=0, appears exactly T_BURST edges after the column command. req_ready rises again T_RP-1 edges after that precharge. Every cycle between commands shows NOP with req_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A user request is present |
| req_ready | output | 1 | The sequencer can take a request this cycle |
| req_we | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | 24 | Flat address {bank, row, column} |
| init_done | output | 1 | Power-up sequence finished and mode register loaded |
| sd_cke | output | 1 | Clock enable to the SDRAM, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 13 | Row, column or mode word; bit 10 selects all-bank precharge |
| sd_dqm | output | 2 | Data mask, high throughout initialization |

## Verification
The bench compares every cycle of the power-up sequence against a command schedule it works out from the parameters. A counter that is off by one would put the precharge, a refresh or the mode load one cycle away from its computed edge. A design that skips a refresh would land the mode load too early. A request is held valid through initialization, so a sequencer that opened its port too soon would issue ACTIVE before LOAD MODE. The access sweep covers all four banks in both directions. It uses the extreme row and column values and scrambles the address right after acceptance. A field split with the wrong bit positions, a field that is not latched, a wrong read/write choice, or a closing precharge that drives the all-bank bit would each show up on the pins.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  // cycles of the power-up quiet period
  function automatic int unsigned power_up_cycles(input int unsigned mhz, input int unsigned usec);
    return mhz * usec;
  endfunction

  // preload value so a command lands exactly gap cycles after the previous one
  function automatic int unsigned gap_preload(input int unsigned gap);
    return (gap == 0) ? 0 : gap - 1;
  endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= CNT_W'(RST_VAL);
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
  import sdram_seq_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int CNT_W     = 16,
  parameter int AP_BIT    = 10,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 8,
  parameter int T_MRD     = 2,
  parameter int T_RCD     = 3,
  parameter int T_BURST   = 4,
  parameter int N_REF     = 8,
  parameter logic [ROW_W-1:0] MODE_WORD = 13'h032,
  localparam int ADDR_W   = BA_W + ROW_W + COL_W,
  localparam int REF_W    = $clog2(N_REF + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              timer_zero,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              accept,
  output logic              timer_load,
  output logic [CNT_W-1:0]  timer_val,
  output sd_cmd_e           cmd_d,
  output logic [BA_W-1:0]   ba_d,
  output logic [ROW_W-1:0]  a_d,
  output logic              init_set
);
  typedef enum logic [2:0] {ST_PWR, ST_REF, ST_MRS, ST_IDLE, ST_COL, ST_CLOSE} st_e;

  function automatic logic [BA_W-1:0] bank_of(input logic [ADDR_W-1:0] ad);
    return ad[ADDR_W-1 -: BA_W];
  endfunction
  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] ad);
    return ad[COL_W +: ROW_W];
  endfunction
  function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] ad);
    return ad[COL_W-1:0];
  endfunction

  st_e               st_q, st_n;
  logic [REF_W-1:0]  ref_q, ref_n;
  logic [BA_W-1:0]   bank_q;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic              latch;

  assign req_ready = (st_q == ST_IDLE) && timer_zero;
  assign accept    = req_ready && req_valid;

  always_comb begin
    st_n       = st_q;
    ref_n      = ref_q;
    cmd_d      = CMD_NOP;
    ba_d       = '0;
    a_d        = '0;
    timer_load = 1'b0;
    timer_val  = '0;
    init_set   = 1'b0;
    latch      = 1'b0;
    unique case (st_q)
      ST_PWR: if (timer_zero) begin
        cmd_d          = CMD_PRE;
        a_d[AP_BIT]    = 1'b1;
        timer_load     = 1'b1;
        timer_val      = CNT_W'(gap_preload(T_RP));
        ref_n          = '0;
        st_n           = ST_REF;
      end
      ST_REF: if (timer_zero) begin
        cmd_d      = CMD_REF;
        timer_load = 1'b1;
        timer_val  = CNT_W'(gap_preload(T_RFC));
        if (ref_q == REF_W'(N_REF - 1)) st_n = ST_MRS;
        else                            ref_n = ref_q + 1'b1;
      end
      ST_MRS: if (timer_zero) begin
        cmd_d      = CMD_LMR;
        a_d        = MODE_WORD;
        timer_load = 1'b1;
        timer_val  = CNT_W'(gap_preload(T_MRD));
        init_set   = 1'b1;
        st_n       = ST_IDLE;
      end
      ST_IDLE: if (accept) begin
        cmd_d      = CMD_ACT;
        ba_d       = bank_of(req_addr);
        a_d        = row_of(req_addr);
        timer_load = 1'b1;
        timer_val  = CNT_W'(gap_preload(T_RCD));
        latch      = 1'b1;
        st_n       = ST_COL;
      end
      ST_COL: if (timer_zero) begin
        cmd_d             = we_q ? CMD_WR : CMD_RD;
        ba_d              = bank_q;
        a_d[COL_W-1:0]    = col_q;
        timer_load        = 1'b1;
        timer_val         = CNT_W'(gap_preload(T_BURST));
        st_n              = ST_CLOSE;
      end
      ST_CLOSE: if (timer_zero) begin
        cmd_d      = CMD_PRE;
        ba_d       = bank_q;
        timer_load = 1'b1;
        timer_val  = CNT_W'(gap_preload(T_RP));
        st_n       = ST_IDLE;
      end
      default: st_n = ST_PWR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_PWR;
      ref_q  <= '0;
      bank_q <= '0;
      col_q  <= '0;
      we_q   <= 1'b0;
    end else begin
      st_q  <= st_n;
      ref_q <= ref_n;
      if (latch) begin
        bank_q <= bank_of(req_addr);
        col_q  <= col_of(req_addr);
        we_q   <= req_we;
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_reg.sv
module sdram_cmd_reg
  import sdram_seq_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int ROW_W = 13,
  parameter int DQM_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  sd_cmd_e          cmd_d,
  input  logic [BA_W-1:0]  ba_d,
  input  logic [ROW_W-1:0] a_d,
  input  logic             init_set,
  output logic [3:0]       cmd_q,
  output logic [BA_W-1:0]  ba_q,
  output logic [ROW_W-1:0] a_q,
  output logic [DQM_W-1:0] dqm_q,
  output logic             init_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      a_q    <= '0;
      dqm_q  <= '1;
      init_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      a_q    <= a_d;
      init_q <= init_q | init_set;
      dqm_q  <= (init_q | init_set) ? '0 : '1;
    end
  end
endmodule

// File: rtl/sdram_seq.sv
module sdram_seq
  import sdram_seq_pkg::*;
#(
  parameter int CLK_MHZ  = 200,
  parameter int INIT_US  = 200,
  parameter int BA_W     = 2,
  parameter int ROW_W    = 13,
  parameter int COL_W    = 9,
  parameter int DQM_W    = 2,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 8,
  parameter int T_MRD    = 2,
  parameter int T_RCD    = 3,
  parameter int T_BURST  = 4,
  parameter int N_REF    = 8,
  parameter logic [ROW_W-1:0] MODE_WORD = 13'h032,
  localparam int ADDR_W   = BA_W + ROW_W + COL_W,
  localparam int INIT_CYC = power_up_cycles(CLK_MHZ, INIT_US),
  localparam int CNT_W    = $clog2(INIT_CYC + T_RP + T_RFC + T_MRD + T_RCD + T_BURST + 1),
  localparam int AP_BIT   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              init_done,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic [DQM_W-1:0]  sd_dqm
);
  logic             timer_zero, timer_load, init_set, accept;
  logic [CNT_W-1:0] timer_val;
  sd_cmd_e          cmd_d;
  logic [BA_W-1:0]  ba_d;
  logic [ROW_W-1:0] a_d;
  logic [3:0]       cmd_pins;

  sdram_gap_timer #(.CNT_W(CNT_W), .RST_VAL(INIT_CYC - 1)) u_timer (
    .clk(clk), .rst(rst), .load(timer_load), .load_val(timer_val), .zero(timer_zero)
  );

  sdram_seq_ctrl #(
    .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W), .AP_BIT(AP_BIT),
    .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .T_RCD(T_RCD), .T_BURST(T_BURST),
    .N_REF(N_REF), .MODE_WORD(MODE_WORD)
  ) u_ctrl (
    .clk(clk), .rst(rst), .timer_zero(timer_zero), .req_valid(req_valid),
    .req_we(req_we), .req_addr(req_addr), .req_ready(req_ready), .accept(accept),
    .timer_load(timer_load), .timer_val(timer_val), .cmd_d(cmd_d), .ba_d(ba_d),
    .a_d(a_d), .init_set(init_set)
  );

  sdram_cmd_reg #(.BA_W(BA_W), .ROW_W(ROW_W), .DQM_W(DQM_W)) u_out (
    .clk(clk), .rst(rst), .cmd_d(cmd_d), .ba_d(ba_d), .a_d(a_d), .init_set(init_set),
    .cmd_q(cmd_pins), .ba_q(sd_ba), .a_q(sd_a), .dqm_q(sd_dqm), .init_q(init_done)
  );

  assign sd_cke = 1'b1;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_pins;
endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int DQM_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       cmd,
  input logic             ap,
  input logic [DQM_W-1:0] dqm,
  input logic             init_done,
  input logic             ready,
  input logic             accept
);
  // R6
  no_early_access_chk: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !(cmd == CMD_ACT || cmd == CMD_RD || cmd == CMD_WR));

  // R6
  ready_gated_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> init_done);

  // R5
  init_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  // R5
  dqm_release_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (dqm == '0));

  // R1
  dqm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> (dqm == '1));

  // R3
  pre_all_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE && !init_done) |-> ap);

  // R10
  pre_single_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE && init_done) |-> !ap);

  // R8
  accept_act_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (cmd == CMD_ACT));

  // R2
  legal_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    cmd inside {CMD_LMR, CMD_REF, CMD_PRE, CMD_ACT, CMD_WR, CMD_RD, CMD_NOP});
endmodule

bind sdram_seq sdram_seq_chk #(.DQM_W(DQM_W)) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd_pins), .ap(sd_a[AP_BIT]), .dqm(sd_dqm),
  .init_done(init_done), .ready(req_ready), .accept(accept)
);

// File: tb/sdram_seq_bench.sv
`timescale 1ns/1ps
module sdram_seq_bench;
  localparam int CLK_MHZ = 200, INIT_US = 1;
  localparam int T_RP = 3, T_RFC = 5, T_MRD = 2, T_RCD = 3, T_BURST = 4, N_REF = 8;
  localparam logic [12:0] MODE = 13'h032;
  localparam int INIT = CLK_MHZ * INIT_US;
  localparam int MRS_AT = INIT + T_RP + N_REF * T_RFC;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, req_valid = 1'b0, req_we = 1'b0;
  logic [23:0] req_addr = '0;
  logic req_ready, init_done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba, sd_dqm;
  logic [12:0] sd_a;
  wire [3:0] pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  sdram_seq #(.CLK_MHZ(CLK_MHZ), .INIT_US(INIT_US), .T_RP(T_RP), .T_RFC(T_RFC),
              .T_MRD(T_MRD), .T_RCD(T_RCD), .T_BURST(T_BURST), .N_REF(N_REF),
              .MODE_WORD(MODE)) u_sdram_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .init_done(init_done), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_a(sd_a), .sd_dqm(sd_dqm)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  int vecs = 0, errs = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s at edge %0d: got %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  function automatic logic [3:0] init_sched(input int c);
    if (c == INIT) return PRE;
    for (int k = 0; k < N_REF; k++)
      if (c == INIT + T_RP + k * T_RFC) return REF;
    if (c == MRS_AT) return LMR;
    return NOP;
  endfunction

  function automatic logic [23:0] mk_addr(input int b, input int row, input int col);
    return 24'(b * (1 << 22) + row * 512 + col);
  endfunction

  task automatic run_req(input int b, input int row, input int col, input bit we, input bit held);
    int r;
    if (!held) begin
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_we = we; req_addr = mk_addr(b, row, col);
    end else begin
      while (!req_ready) @(negedge clk);
    end
    r = cyc;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~req_addr; req_we = ~we;
    // R8 ACTIVE on the accepting edge, R7 field split
    chk("R8", "active cmd", pins, ACT);
    chk("R7", "active bank", sd_ba, b);
    chk("R7", "active row", sd_a, row);
    chk("R8", "edge of active", cyc, r + 1);
    for (int off = 1; off <= T_RCD + T_BURST + T_RP - 1; off++) begin
      @(negedge clk);
      if (off == T_RCD) begin
        chk("R9", "column cmd", pins, we ? WR : RD);
        chk("R9", "column bank", sd_ba, b);
        chk("R7", "column addr", sd_a[8:0], col);
        chk("R9", "auto-close bit", sd_a[10], 0);
      end else if (off == T_RCD + T_BURST) begin
        chk("R10", "close cmd", pins, PRE);
        chk("R10", "close bank", sd_ba, b);
        chk("R10", "single-bank bit", sd_a[10], 0);
      end else begin
        chk("R10", "gap nop", pins, NOP);
      end
      chk("R10", "ready timing", req_ready, (off == T_RCD + T_BURST + T_RP - 1) ? 1 : 0);
    end
  endtask

  initial begin
    // request held valid from reset through initialization (R6)
    req_valid = 1'b1; req_we = 1'b1; req_addr = mk_addr(2, 5, 7);
    repeat (3) @(negedge clk);
    chk("R1", "reset cmd", pins, NOP);
    chk("R1", "reset cke", sd_cke, 1);
    chk("R1", "reset dqm", sd_dqm, 3);
    chk("R1", "reset ready", req_ready, 0);
    chk("R1", "reset init_done", init_done, 0);
    rst = 1'b0;
    for (int c = 1; c <= MRS_AT; c++) begin
      @(negedge clk);
      if (c < INIT)       chk("R3", "quiet nop", pins, NOP);
      else if (c < INIT + T_RP) chk("R3", "precharge slot", pins, init_sched(c));
      else if (c < MRS_AT) chk("R4", "refresh slot", pins, init_sched(c));
      else                chk("R5", "mode load slot", pins, LMR);
      if (c == INIT) chk("R3", "all-bank bit", sd_a[10], 1);
      if (c == MRS_AT) begin
        chk("R5", "mode word", sd_a, MODE);
        chk("R5", "mode bank", sd_ba, 0);
        chk("R5", "init_done", init_done, 1);
        chk("R5", "dqm released", sd_dqm, 0);
      end else begin
        chk("R5", "init_done early", init_done, 0);
        chk("R1", "dqm held", sd_dqm, 3);
      end
      chk("R6", "ready during init", req_ready, 0);
      chk("R1", "cke", sd_cke, 1);
    end
    for (int k = 1; k < T_MRD - 1; k++) begin
      @(negedge clk);
      chk("R6", "ready before tMRD", req_ready, 0);
    end
    @(negedge clk);
    chk("R6", "first ready edge", cyc, MRS_AT + T_MRD - 1);
    chk("R6", "first ready", req_ready, 1);
    run_req(2, 5, 7, 1'b1, 1'b1);
    for (int b = 0; b < 4; b++)
      for (int w = 0; w < 2; w++)
        for (int p = 0; p < 3; p++) begin
          int row, col;
          row = (p == 0) ? 0 : (p == 1) ? 8191 : b * 1000 + 37;
          col = (p == 0) ? 511 : (p == 1) ? 0 : b * 50 + 3;
          run_req(b, row, col, w[0], 1'b0);
        end
    repeat (4) @(negedge clk);
    chk("R5", "init_done stays", init_done, 1);
    chk("R10", "idle nop", pins, NOP);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vecs++; errs++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule